// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This engine moves a block of words between a peripheral and memory over a system bus that it shares with a processor. Software loads four settings through a small register port: a transfer direction, a fixed device address, a memory start address and a word count. Software then sets a go bit. From that point the engine runs the whole block with no further help from software. When the last word has landed, it raises an interrupt.

The engine is not attached to the peripheral, so it has to read each word into an internal holding register and then write it out. A word therefore costs two bus accesses: a read from the source and a write to the destination. Each access is a separate request/grant exchange. A grant is used for exactly one cycle. The request then drops for one cycle, so the processor can use the bus between accesses. The processor only stalls at its own bus accesses and never switches context.

The bus handshake works like a valid/ready pair. `bus_req` is the valid signal and `bus_gnt` is the ready signal. An access takes place in a cycle where both are high. While the grant is withheld, the request stays up and nothing in the engine changes. That is the block's only back-pressure.

Top module: `cs_dma_engine`

## Requirements
- R1: While idle, writes to the setting registers read back unchanged. The selector values are 0 = control (bit 1 = direction), 1 = device address, 2 = memory address, 3 = word count and 4 = status (bit 0 = busy, bit 1 = done). A control write with bit 0 low does not start a transfer.
- R2: A control write with bit 0 high, made while idle with a non-zero count, starts a transfer. From the next cycle, busy reads 1 and `bus_req` is high.
- R3: Each word uses exactly two granted cycles. After every granted cycle, `bus_req` is low in the following cycle.
- R4: With direction 0, the first access of a word reads the device address with `bus_we` low. The second access writes the value read to the current memory address with `bus_we` high.
- R5: With direction 1, the first access reads the current memory address. The second access writes the value read to the device address.
- R6: The memory address advances by one after each memory-side access. The count drops by one after each word's second access, so at the end the registers read start+length and 0.
- R7: `bus_addr`, `bus_we` and `bus_wdata` are all zero in every cycle where `bus_req` and `bus_gnt` are not both high.
- R8: While `bus_req` is high and `bus_gnt` is low, the request stays high and the engine makes no progress.
- R9: In the cycle after the last word's write access, `irq` and done are 1 and busy is 0.
- R10: Done (and `irq`) stays set until software writes the status register with bit 1 set. A status write with bit 1 clear leaves it set.
- R11: While busy, a go write and writes to the direction, device address, memory address and count are ignored.
- R12: A go with a count of 0 sets done in the next cycle, never sets busy, and makes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| irq | output | 1 | Completion interrupt (the done flag) |
| bus_req | output | 1 | Bus request (valid) |
| bus_gnt | input | 1 | Bus grant (ready) |
| bus_addr | output | 32 | Bus address, driven only in granted cycles |
| bus_we | output | 1 | Bus write enable, driven only in granted cycles |
| bus_wdata | output | 32 | Bus write data, driven only in granted write cycles |
| bus_rdata | input | 32 | Bus read data, taken in a granted read cycle |

## Verification
The hardest case to reach is software traffic that lands while the engine is parked with its request up and no grant. Examples are a second go, or a new device or memory address arriving mid-block. Any leak from such a write would only show up in later bus accesses. To reach this case, the bench arbiter holds the grant back on a pseudo-random pattern. The bench issues the stray writes right after a go, while busy is confirmed high. A scoreboard of expected accesses, built from the original settings, then exposes any address or data that the writes disturbed.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_REQ,
    ST_SRC_REL,
    ST_DST_REQ,
    ST_DST_REL
  } dma_state_e;

  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DEV  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MEM  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_LEN  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;

  localparam int unsigned CTRL_GO   = 0;
  localparam int unsigned CTRL_DIR  = 1;
  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_DONE = 1;

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned RW        = 32,
  parameter int unsigned ADDR_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  input  logic             busy,
  input  logic             acc_src,
  input  logic             acc_dst,
  input  logic             set_done,
  output logic             dir,
  output logic [AW-1:0]    dev_addr,
  output logic [AW-1:0]    mem_addr,
  output logic [CW-1:0]    count,
  output logic             start_go,
  output logic             count_zero,
  output logic             count_last,
  output logic             done
);

  localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic cfg_ok;
  logic mem_adv;
  logic clr_done;

  assign cfg_ok     = reg_we && !busy;
  assign start_go   = cfg_ok && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_GO];
  assign mem_adv    = (acc_src && dir) || (acc_dst && !dir);
  assign clr_done   = reg_we && (reg_sel == SEL_STAT) && reg_wdata[STAT_DONE];
  assign count_zero = (count == '0);
  assign count_last = (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir      <= 1'b0;
      dev_addr <= '0;
      mem_addr <= '0;
      count    <= '0;
      done     <= 1'b0;
    end else begin
      if (cfg_ok && reg_sel == SEL_CTRL) dir      <= reg_wdata[CTRL_DIR];
      if (cfg_ok && reg_sel == SEL_DEV)  dev_addr <= reg_wdata[AW-1:0];

      if (mem_adv)                            mem_addr <= mem_addr + STEP;
      else if (cfg_ok && reg_sel == SEL_MEM)  mem_addr <= reg_wdata[AW-1:0];

      if (acc_dst)                            count <= count - ONE;
      else if (cfg_ok && reg_sel == SEL_LEN)  count <= reg_wdata[CW-1:0];

      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[CTRL_DIR] = dir;
      SEL_DEV:  reg_rdata = RW'(dev_addr);
      SEL_MEM:  reg_rdata = RW'(mem_addr);
      SEL_LEN:  reg_rdata = RW'(count);
      SEL_STAT: begin
        reg_rdata[STAT_BUSY] = busy;
        reg_rdata[STAT_DONE] = done;
      end
      default:  reg_rdata = '0;
    endcase
  end

  // R6: count steps down by one per completed word
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dst |=> count == $past(count) - ONE);

  // R6: memory pointer advances after each memory-side access
  p_mem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_adv |=> mem_addr == $past(mem_addr) + STEP);

  // R11: settings frozen while a block is in flight
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dev_addr) && $stable(dir));

  // R10: done is sticky until a write-one-to-clear
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_done |=> done);

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic count_zero,
  input  logic count_last,
  input  logic bus_gnt,
  output logic busy,
  output logic bus_req,
  output logic acc_src,
  output logic acc_dst,
  output logic set_done
);

  dma_state_e state, state_nx;

  assign busy     = (state != ST_IDLE);
  assign bus_req  = (state == ST_SRC_REQ) || (state == ST_DST_REQ);
  assign acc_src  = (state == ST_SRC_REQ) && bus_gnt;
  assign acc_dst  = (state == ST_DST_REQ) && bus_gnt;
  assign set_done = ((state == ST_IDLE) && start_go && count_zero) ||
                    (acc_dst && count_last);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (start_go && !count_zero) state_nx = ST_SRC_REQ;
      ST_SRC_REQ: if (bus_gnt) state_nx = ST_SRC_REL;
      ST_SRC_REL: state_nx = ST_DST_REQ;
      ST_DST_REQ: if (bus_gnt) state_nx = count_last ? ST_IDLE : ST_DST_REL;
      ST_DST_REL: state_nx = ST_SRC_REQ;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R3: a grant is used for one cycle, then the bus is released
  p_release_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> !bus_req);

  // R8: with grant withheld the request holds and nothing advances
  p_wait_for_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(state));

  // R12: zero-length go never leaves idle
  p_zero_len_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && start_go && count_zero |=> !busy);

  // R9: last write access returns the engine to idle
  p_last_word_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dst && count_last |=> !busy);

endmodule

// File: rtl/cs_dma_busif.sv
module cs_dma_busif #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_src,
  input  logic          acc_dst,
  input  logic          dir,
  input  logic [AW-1:0] dev_addr,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata
);

  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (acc_src) hold_q <= bus_rdata;
  end

  always_comb begin
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    if (acc_src) begin
      bus_addr = dir ? mem_addr : dev_addr;
    end else if (acc_dst) begin
      bus_addr  = dir ? dev_addr : mem_addr;
      bus_we    = 1'b1;
      bus_wdata = hold_q;
    end
  end

endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import cs_dma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned RW        = 32,
  parameter int unsigned ADDR_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  output logic             irq,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_we,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata
);

  logic          busy, acc_src, acc_dst, set_done;
  logic          dir, start_go, count_zero, count_last, done;
  logic [AW-1:0] dev_addr, mem_addr;
  logic [CW-1:0] count;

  cs_dma_regs #(.AW(AW), .CW(CW), .RW(RW), .ADDR_STEP(ADDR_STEP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .acc_src(acc_src), .acc_dst(acc_dst), .set_done(set_done),
    .dir(dir), .dev_addr(dev_addr), .mem_addr(mem_addr), .count(count),
    .start_go(start_go), .count_zero(count_zero), .count_last(count_last), .done(done)
  );

  cs_dma_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_go(start_go), .count_zero(count_zero), .count_last(count_last),
    .bus_gnt(bus_gnt), .busy(busy), .bus_req(bus_req),
    .acc_src(acc_src), .acc_dst(acc_dst), .set_done(set_done)
  );

  cs_dma_busif #(.AW(AW), .DW(DW)) u_busif (
    .clk(clk), .rst_n(rst_n),
    .acc_src(acc_src), .acc_dst(acc_dst), .dir(dir),
    .dev_addr(dev_addr), .mem_addr(mem_addr), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata)
  );

  assign irq = done;

  // R7: outputs quiet outside granted cycles
  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_gnt) |-> (bus_addr == '0) && !bus_we && (bus_wdata == '0));

endmodule

// File: tb/cs_dma_engine_tb_top.sv
module cs_dma_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, bus_we;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int stall_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  bit prev_acc = 1'b0;

  typedef struct packed {
    logic [31:0] a;
    logic        we;
    logic [31:0] d;
  } acc_t;
  acc_t exp_q[$];

  function automatic logic [31:0] mdl(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9bdf;
  endfunction

  assign bus_rdata = mdl(bus_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arbiter: grant updated on the falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n)               bus_gnt <= 1'b0;
    else if (stall_mode == 0) bus_gnt <= bus_req;
    else                      bus_gnt <= bus_req && lfsr[0] && lfsr[2];
  end

  // monitor: pops the scoreboard on every granted cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_acc) chk(!bus_req, "R3 release after grant", 32'(bus_req), 32'd0);
      if (bus_req && bus_gnt) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R12 unexpected bus access", bus_addr, 32'd0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(bus_addr == e.a, "R4/R5 access address", bus_addr, e.a);
          chk(bus_we == e.we, "R4/R5 access direction", 32'(bus_we), 32'(e.we));
          chk(bus_wdata == e.d, "R4/R5 access data", bus_wdata, e.d);
        end
      end else begin
        chk(bus_addr == 0 && !bus_we && bus_wdata == 0, "R7/R8 quiet bus", bus_addr, 32'd0);
      end
      prev_acc = bus_req && bus_gnt;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic push_xfer(input bit dir, input logic [31:0] dev, input logic [31:0] mem, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] m;
      m = mem + 32'(i);
      if (!dir) begin
        exp_q.push_back('{a: dev, we: 1'b0, d: 32'd0});
        exp_q.push_back('{a: m, we: 1'b1, d: mdl(dev)});
      end else begin
        exp_q.push_back('{a: m, we: 1'b0, d: 32'd0});
        exp_q.push_back('{a: dev, we: 1'b1, d: mdl(m)});
      end
    end
  endtask

  task automatic start_xfer(input bit dir, input logic [31:0] dev, input logic [31:0] mem, input int n, input int smode);
    logic [31:0] v;
    stall_mode = smode;
    wr(3'd1, dev); wr(3'd2, mem); wr(3'd3, 32'(n));
    push_xfer(dir, dev, mem, n);
    wr(3'd0, {30'd0, dir, 1'b1});
    rd(3'd4, v);
    chk(v[0] == 1'b1, "R2 busy after go", v, 32'd1);
    chk(bus_req == 1'b1, "R2 request after go", 32'(bus_req), 32'd1);
  endtask

  task automatic finish_xfer(input logic [31:0] mem, input int n);
    logic [31:0] v;
    int c = 0;
    while (!irq && c < 5000) begin @(negedge clk); c++; end
    chk(irq == 1'b1, "R9 irq at end", 32'(irq), 32'd1);
    rd(3'd4, v);
    chk(v[1:0] == 2'b10, "R9 done set busy clear", v, 32'd2);
    chk(exp_q.size() == 0, "R3 two accesses per word", 32'(exp_q.size()), 32'd0);
    rd(3'd2, v);
    chk(v == mem + 32'(n), "R6 final memory address", v, mem + 32'(n));
    rd(3'd3, v);
    chk(v == 32'd0, "R6 final count", v, 32'd0);
    wr(3'd4, 32'd0);
    chk(irq == 1'b1, "R10 write of zero keeps irq", 32'(irq), 32'd1);
    wr(3'd4, 32'd2);
    chk(irq == 1'b0, "R10 write one clears irq", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(3'd4, v); chk(v == 0, "R1 reset status", v, 32'd0);
    rd(3'd2, v); chk(v == 0, "R1 reset memory address", v, 32'd0);
    chk(irq == 0 && bus_req == 0, "R1 reset outputs", 32'({irq, bus_req}), 32'd0);

    // R1 readback; control write without go
    wr(3'd1, 32'hCAFE_0010); wr(3'd2, 32'h0000_4000); wr(3'd3, 32'd7);
    wr(3'd0, 32'd2);
    rd(3'd0, v); chk(v == 32'd2, "R1 direction readback", v, 32'd2);
    rd(3'd1, v); chk(v == 32'hCAFE_0010, "R1 device readback", v, 32'hCAFE_0010);
    rd(3'd2, v); chk(v == 32'h0000_4000, "R1 memory readback", v, 32'h0000_4000);
    rd(3'd3, v); chk(v == 32'd7, "R1 count readback", v, 32'd7);
    repeat (4) @(negedge clk);
    chk(bus_req == 0, "R1 no start without go", 32'(bus_req), 32'd0);

    // R4 device to memory, no stalls
    start_xfer(1'b0, 32'h0000_0300, 32'h0000_1000, 4, 0);
    finish_xfer(32'h0000_1000, 4);
    // R5 memory to device, with stalls (R8)
    start_xfer(1'b1, 32'h0000_0304, 32'h0000_2000, 5, 1);
    finish_xfer(32'h0000_2000, 5);
    // single word boundary
    start_xfer(1'b0, 32'h0000_0308, 32'h0000_3000, 1, 1);
    finish_xfer(32'h0000_3000, 1);
    // memory pointer wraps
    start_xfer(1'b1, 32'h0000_030C, 32'hFFFF_FFFE, 3, 0);
    finish_xfer(32'hFFFF_FFFE, 3);

    // R11: writes while busy are ignored
    start_xfer(1'b0, 32'h0000_0100, 32'h0000_5000, 6, 1);
    wr(3'd1, 32'h0000_0999);
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h0000_5555);
    wr(3'd3, 32'd40);
    rd(3'd1, v); chk(v == 32'h0000_0100, "R11 device held while busy", v, 32'h100);
    finish_xfer(32'h0000_5000, 6);
    rd(3'd0, v); chk(v == 32'd0, "R11 direction held", v, 32'd0);
    repeat (10) @(negedge clk);
    chk(bus_req == 0, "R11 no second transfer", 32'(bus_req), 32'd0);

    // R12: zero-length go
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd1);
    chk(irq == 1'b1, "R12 done next cycle", 32'(irq), 32'd1);
    rd(3'd4, v); chk(v[0] == 1'b0, "R12 busy never set", v, 32'd2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(bus_req == 0, "R12 no request", 32'(bus_req), 32'd0);
    end
    wr(3'd4, 32'd2);
    chk(irq == 1'b0, "R10 clear after zero-length", 32'(irq), 32'd0);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule